// File: doc/BRIEF.md
# Wormhole Crossbar Channel Router

This block is one switching stage of a crossbar that carries 128-bit words. A single input stream delivers frames. The head word of every frame is a route word. The stage consumes that word and does not forward it. It decodes an output channel from the word and then holds that channel open as a wormhole. Every later word of the frame goes to that channel unchanged, including any route word meant for a following stage. The path closes once the word marked last has been handed over.

The route word is built from narrow five-bit slices. Each slice holds a four-bit channel field and a parity bit. A word whose slices disagree, whose parity is broken, whose code is out of range or whose reserved bits are set is not routed. The stage raises an error strobe and silently drains the rest of that frame. Backpressure from the selected output passes straight back to the input. No word is buffered inside the stage.

Top module: `wormhole_router`

## Requirements
- R1: The route word is read as 25 slices. Slice k occupies bits 5k+4..5k, with the channel field in bits 5k+3..5k and a parity bit in bit 5k+4. Each slice must have even parity across its five bits. Bits 127..125 are reserved and must be zero. When every slice carries the same code c with 1 <= c <= 14, the frame goes to output channel index c-1, which is bit c-1 of the output vectors.
- R2: While waiting for a route word, in_ready_o is 1 and no out_valid_o bit is set. The accepted route word is never forwarded.
- R3: Once a channel is open, each input word appears on out_data_o with the same data and last flag, under the selected channel's valid bit. The channel stays open until a word with in_last_i=1 completes a handshake. The next accepted word is then decoded as a new route word.
- R4: If any slice of a route word fails parity, or a reserved bit is set, route_err_o is 1 in the cycle that word is presented. No channel opens, and the words of that frame up to and including its last word are discarded.
- R5: A route word whose slices disagree, or whose common code is 0 or 15, is treated as in R4. This includes the all-zero word, which decodes as code 0.
- R6: While a channel is open, in_ready_o equals out_ready_i of the selected channel and ignores every other ready bit. A last word that is stalled does not close the path.
- R7: At most one bit of out_valid_o is set, and only the open channel's bit can be set.
- R8: An active-low reset closes any open path or drop. After reset the block waits for a route word, with in_ready_o=1 and out_valid_o=0.
- R9: A route word that carries in_last_i=1 is consumed and opens no channel. If it is invalid, route_err_o still flags it, and the next word is again treated as a route word.
- R10: While a frame is being discarded, in_ready_o is 1 whatever out_ready_i holds, and out_valid_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 128 | Input word |
| in_valid_i | input | 1 | Input word valid |
| in_last_i | input | 1 | Input word closes the frame |
| in_ready_o | output | 1 | Input word accepted this cycle when valid |
| out_data_o | output | 128 | Data lane shared by all output channels |
| out_valid_o | output | 14 | Per-channel valid |
| out_last_o | output | 14 | Per-channel last flag |
| out_ready_i | input | 14 | Per-channel ready |
| route_err_o | output | 1 | Presented route word is rejected |

## Verification
Two events can fall in the same cycle: closing the path on a last word, and backpressure from the selected channel. The bench holds a last word while the open channel's ready is low and the other ready bits are high. The path must stay open and must close only in the cycle the selected ready rises. The bench judges this by whether the word that follows is decoded as a route word. A second overlap is decode and close on one word, when a route word carries the last flag. The bench checks that no channel opens and that the following word is decoded afresh, with good and bad route words alike.

// File: rtl/wxr_pkg.sv
package wxr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_DROP = 2'd2
  } route_st_e;
endpackage

// File: rtl/wxr_addr_decode.sv
module wxr_addr_decode #(
  parameter int DATA_W  = 128,
  parameter int SLICE_W = 5,
  parameter int NUM_CH  = 14,
  localparam int FIELD_W   = SLICE_W - 1,
  localparam int NUM_SLICE = DATA_W / SLICE_W,
  localparam int SPARE_W   = DATA_W - NUM_SLICE * SLICE_W,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic [DATA_W-1:0] word_i,
  output logic              ok_o,
  output logic [CH_W-1:0]   ch_o
);
  logic [NUM_SLICE-1:0] par_ok, agree;
  logic [FIELD_W-1:0]   code;
  logic                 spare_ok;

  assign code = word_i[FIELD_W-1:0];

  for (genvar k = 0; k < NUM_SLICE; k++) begin : g_slice
    logic [SLICE_W-1:0] s;
    assign s         = word_i[k*SLICE_W +: SLICE_W];
    assign par_ok[k] = ~^s;
    assign agree[k]  = (s[FIELD_W-1:0] == code);
  end

  if (SPARE_W > 0) begin : g_spare
    assign spare_ok = (word_i[DATA_W-1 -: SPARE_W] == '0);
  end else begin : g_nospare
    assign spare_ok = 1'b1;
  end

  assign ok_o = (&par_ok) & (&agree) & spare_ok & (code != '0) & (32'(code) <= NUM_CH);
  assign ch_o = CH_W'(code - 1'b1);
endmodule

// File: rtl/wxr_route_fsm.sv
module wxr_route_fsm
  import wxr_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic            in_last_i,
  input  logic            in_ready_i,
  input  logic            dec_ok_i,
  input  logic [CH_W-1:0] dec_ch_i,
  output route_st_e       st_o,
  output logic [CH_W-1:0] sel_o,
  output logic            err_o
);
  logic hs;
  assign hs = in_valid_i & in_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o  <= ST_IDLE;
      sel_o <= '0;
    end else begin
      case (st_o)
        ST_IDLE: if (hs) begin
          if (!dec_ok_i) begin
            st_o <= in_last_i ? ST_IDLE : ST_DROP;
          end else begin
            sel_o <= dec_ch_i;
            if (!in_last_i) st_o <= ST_OPEN;
          end
        end
        ST_OPEN: if (hs && in_last_i) st_o <= ST_IDLE;
        ST_DROP: if (hs && in_last_i) st_o <= ST_IDLE;
        default: st_o <= ST_IDLE;
      endcase
    end
  end

  assign err_o = (st_o == ST_IDLE) & in_valid_i & ~dec_ok_i;

  p_close_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_o == ST_OPEN && hs && in_last_i) |=> st_o == ST_IDLE);
  p_hold_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_o == ST_OPEN && !(hs && in_last_i)) |=> (st_o == ST_OPEN && $stable(sel_o)));
  p_drop_to_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_o == ST_DROP && !(hs && in_last_i)) |=> st_o == ST_DROP);
endmodule

// File: rtl/wxr_out_demux.sv
module wxr_out_demux #(
  parameter int NUM_CH = 14,
  parameter int CH_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic [CH_W-1:0]   sel_i,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  input  logic [NUM_CH-1:0] out_ready_i,
  output logic [NUM_CH-1:0] out_valid_o,
  output logic [NUM_CH-1:0] out_last_o,
  output logic              sel_ready_o
);
  logic [NUM_CH-1:0] hit;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign hit[i]         = open_i && (sel_i == CH_W'(i));
    assign out_valid_o[i] = hit[i] & in_valid_i;
    assign out_last_o[i]  = hit[i] & in_valid_i & in_last_i;
  end

  assign sel_ready_o = |(hit & out_ready_i);

  p_one_channel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_valid_o));
endmodule

// File: rtl/wormhole_router.sv
module wormhole_router
  import wxr_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int SLICE_W = 5,
  parameter int NUM_CH  = 14,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [NUM_CH-1:0] out_valid_o,
  output logic [NUM_CH-1:0] out_last_o,
  input  logic [NUM_CH-1:0] out_ready_i,
  output logic              route_err_o
);
  route_st_e       st;
  logic [CH_W-1:0] sel, dec_ch;
  logic            dec_ok, sel_ready;

  wxr_addr_decode #(.DATA_W(DATA_W), .SLICE_W(SLICE_W), .NUM_CH(NUM_CH)) u_dec (
    .word_i (in_data_i),
    .ok_o   (dec_ok),
    .ch_o   (dec_ch)
  );

  wxr_route_fsm #(.CH_W(CH_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_last_i  (in_last_i),
    .in_ready_i (in_ready_o),
    .dec_ok_i   (dec_ok),
    .dec_ch_i   (dec_ch),
    .st_o       (st),
    .sel_o      (sel),
    .err_o      (route_err_o)
  );

  wxr_out_demux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dmx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .open_i      (st == ST_OPEN),
    .sel_i       (sel),
    .in_valid_i  (in_valid_i),
    .in_last_i   (in_last_i),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .sel_ready_o (sel_ready)
  );

  // idle and drop always accept; open follows the selected channel
  assign in_ready_o = (st == ST_OPEN) ? sel_ready : 1'b1;
  assign out_data_o = in_data_i;

  p_idle_no_fwd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != ST_OPEN) |-> out_valid_o == '0);
  p_err_no_route_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_err_o |=> out_valid_o == '0);
  p_drop_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_DROP) |-> in_ready_o);
endmodule

// File: tb/tb_wormhole_router.sv
module tb_wormhole_router;
  localparam int DW = 128;
  localparam int NC = 14;
  localparam int NS = 25;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_valid = 1'b0, in_last = 1'b0;
  logic          in_ready;
  logic [DW-1:0] out_data;
  logic [NC-1:0] out_valid, out_last;
  logic [NC-1:0] out_ready = '0;
  logic          route_err;

  always #10 clk = ~clk;

  wormhole_router dut (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_last_i(in_last), .in_ready_o(in_ready), .out_data_o(out_data),
    .out_valid_o(out_valid), .out_last_o(out_last), .out_ready_i(out_ready),
    .route_err_o(route_err)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_st = 0;  // 0 await route, 1 open, 2 drop
  int m_sel = 0;

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk_addr(int code, int bad_par, int odd_slice, int odd_code);
    logic [DW-1:0] w = '0;
    for (int k = 0; k < NS; k++) begin
      logic [3:0] f = (k == odd_slice) ? 4'(odd_code) : 4'(code);
      logic p = ^f;
      if (k == bad_par) p = ~p;
      w[5*k +: 4] = f;
      w[5*k+4] = p;
    end
    return w;
  endfunction

  // expected channel index, or -1 when the word must be rejected
  function automatic int ref_route(logic [DW-1:0] w);
    logic [3:0] c = w[3:0];
    if (w[127:125] != 0) return -1;
    for (int k = 0; k < NS; k++) begin
      if (^w[5*k +: 5]) return -1;
      if (w[5*k +: 4] != c) return -1;
    end
    if (c == 0 || c > NC) return -1;
    return int'(c) - 1;
  endfunction

  function automatic logic [DW-1:0] rnd_word();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [DW-1:0] rnd_route();
    int kind = $urandom_range(0, 10);
    logic [DW-1:0] w;
    int c = $urandom_range(1, NC);
    case (kind)
      6: w = mk_addr(c, $urandom_range(0, NS-1), -1, 0);
      7: w = mk_addr(c, -1, $urandom_range(1, NS-1), (c % NC) + 1);
      8: w = mk_addr(($urandom_range(0, 1) == 1) ? 15 : 0, -1, -1, 0);
      9: w = '0;
      10: begin w = mk_addr(c, -1, -1, 0); w[125 + $urandom_range(0, 2)] = 1'b1; end
      default: w = mk_addr(c, -1, -1, 0);
    endcase
    return w;
  endfunction

  // inputs already driven at negedge; check just after, then advance one clock
  task automatic step(string tag);
    logic exp_rdy;
    logic [NC-1:0] exp_v, exp_l;
    bit hs;
    int r;
    #1;
    r = ref_route(in_data);
    exp_v = '0; exp_l = '0;
    if (m_st == 1) begin
      exp_rdy = out_ready[m_sel];
      exp_v[m_sel] = in_valid;
      exp_l[m_sel] = in_valid & in_last;
    end else begin
      exp_rdy = 1'b1;
    end
    if (m_st == 0) begin
      chk({tag, " R2"}, "ready await", DW'(in_ready), DW'(exp_rdy));
      chk({tag, " R2"}, "valid await", DW'(out_valid), DW'(exp_v));
      chk({tag, " R4 R5"}, "route_err", DW'(route_err), DW'(in_valid && r < 0));
    end else if (m_st == 1) begin
      chk({tag, " R6"}, "ready open", DW'(in_ready), DW'(exp_rdy));
      chk({tag, " R7 R1"}, "valid open", DW'(out_valid), DW'(exp_v));
      chk({tag, " R3"}, "last open", DW'(out_last), DW'(exp_l));
      if (in_valid) chk({tag, " R3"}, "data", out_data, in_data);
      chk({tag, " R3"}, "no err", DW'(route_err), DW'(0));
    end else begin
      chk({tag, " R10"}, "ready drop", DW'(in_ready), DW'(1));
      chk({tag, " R10 R4"}, "valid drop", DW'(out_valid), DW'(0));
    end
    hs = in_valid && exp_rdy;
    @(posedge clk);
    if (hs) begin
      if (m_st == 0) begin
        if (r < 0) m_st = in_last ? 0 : 2;
        else begin m_sel = r; m_st = in_last ? 0 : 1; end
      end else if (in_last) m_st = 0;
    end
    @(negedge clk);
  endtask

  task automatic drive(logic v, logic [DW-1:0] d, logic l, logic [NC-1:0] rdy);
    in_valid = v; in_data = d; in_last = l; out_ready = rdy;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    chk("R8", "reset valid", DW'(out_valid), DW'(0));
    chk("R8", "reset ready", DW'(in_ready), DW'(1));
    rst_n = 1'b1;
    @(negedge clk);

    // R1: highest channel, stall last word while other readies high (R6)
    drive(1, mk_addr(14, -1, -1, 0), 0, '1); step("R1 route ch14");
    drive(1, rnd_word(), 0, 14'h2000); step("R1 fwd");
    drive(1, rnd_word(), 1, 14'h1fff); step("R6 stalled last");
    drive(1, rnd_word(), 1, 14'h1fff); step("R6 stalled last again");
    chk("R6", "still open", DW'(m_st), DW'(1));
    drive(1, in_data, 1, 14'h2000); step("R3 close");
    // next word is a route word again (R3)
    drive(1, mk_addr(1, -1, -1, 0), 0, 14'h0001); step("R3 new route ch1");
    drive(1, rnd_word(), 1, 14'h0001); step("R3 close ch1");
    // R5 all-zero, then drain with backpressure everywhere (R10)
    drive(1, '0, 0, '0); step("R5 zero word");
    drive(1, rnd_word(), 0, '0); step("R10 drain");
    drive(1, rnd_word(), 1, '0); step("R10 drain last");
    // R9 route word with last: good then bad
    drive(1, mk_addr(5, -1, -1, 0), 1, '1); step("R9 good single");
    drive(1, mk_addr(3, 7, -1, 0), 1, '1); step("R9 bad single");
    chk("R9", "awaiting route", DW'(m_st), DW'(0));
    // R4 parity, R5 code 15 and disagreement
    drive(1, mk_addr(9, 0, -1, 0), 1, '1); step("R4 parity");
    drive(1, mk_addr(15, -1, -1, 0), 1, '1); step("R5 code15");
    drive(1, mk_addr(4, -1, 24, 6), 1, '1); step("R5 disagree");
    // R8 reset mid-frame
    drive(1, mk_addr(7, -1, -1, 0), 0, '1); step("R8 open ch7");
    drive(1, rnd_word(), 0, '1);
    rst_n = 1'b0; #1;
    chk("R8", "valid in reset", DW'(out_valid), DW'(0));
    chk("R8", "ready in reset", DW'(in_ready), DW'(1));
    m_st = 0;
    @(negedge clk); rst_n = 1'b1;
    drive(1, rnd_word(), 0, '1); step("R8 after reset");
    drive(0, '0, 0, '1); step("R8 idle");

    for (int i = 0; i < 6000; i++) begin
      logic v = ($urandom_range(0, 3) != 0);
      logic [NC-1:0] rdy = NC'($urandom) | NC'($urandom);
      if (m_st == 0) drive(v, rnd_route(), ($urandom_range(0, 9) == 0), rdy);
      else drive(v, rnd_word(), ($urandom_range(0, 3) == 0), rdy);
      step("rand");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule